// File: doc/BRIEF.md
# Credit-Aware Virtual Channel Allocator

This block assigns output virtual channels to input virtual channels inside a router with `PORTS` ports and `VCS` virtual channels per port. Both the input side and the output side are indexed by a flat number, port times `VCS` plus the channel number, so there are `N = PORTS*VCS` requesters and `N` resources. Route computation happens elsewhere. Each input channel presents a vector of candidate output channels, and the allocator turns those candidates into one held allocation per input channel.

A candidate becomes a pending request only if the output channel has all of its downstream credits back. Every free output channel runs a round-robin arbiter over its pending requesters and names one winner each cycle. An input channel that wins several output channels keeps the one with the largest credit count and drops every other request it has pending. The allocation is registered and held until the input channel signals that its tail flit has left. That release frees the output channel for a new grant.

Top module: `vca_alloc`

## Requirements
- R1: A candidate bit `req_i[i*N+o]` becomes a pending request only in a cycle where `full_i[o]` is 1. A candidate presented while `full_i[o]` is 0 never produces a grant.
- R2: At any time, an output channel is allocated to at most one input channel. A requester waiting on an allocated output channel gets no grant until that channel is released.
- R3: An input channel that wins several output channels in the same cycle keeps the one with the strictly largest `credit_i` count. A tie goes to the lowest output index.
- R4: If every output channel an input channel wins has zero credits, the lowest-indexed of them is kept.
- R5: Once an input channel keeps an output channel, all of its other pending requests are withdrawn. An output channel it won but did not keep goes to its next requester on the following cycle.
- R6: A `release_i[i]` pulse on an allocated input channel clears `grant_valid_o[i]` on the next clock edge and frees its output channel for a new grant.
- R7: Each output channel arbitrates round-robin. Its priority pointer moves to one past the winner only when the winner keeps that channel, so two inputs that keep contending take turns.
- R8: `grant_ovc_o[i*OW +: OW]` carries the kept output channel as port*VCS+vc. For a request presented in cycle t, `grant_valid_o[i]` rises after the second clock edge.
- R9: After reset, no grant is valid.
- R10: An allocation holds its valid flag and output channel unchanged until it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N*N | Candidate output channels; bit i*N+o means input i may use output o |
| full_i | input | N | Per output channel: all downstream credits are returned |
| credit_i | input | N*CRED_W | Per output channel downstream credit count |
| release_i | input | N | Per input channel: tail flit departed, free the allocation |
| grant_valid_o | output | N | Per input channel: an output channel is allocated |
| grant_ovc_o | output | N*OW | Per input channel: allocated output channel index |

## Verification
The bench builds the allocator with 3 ports and 2 channels per port, which gives six requesters and six resources, and uses 3-bit credit counts. At this size, several inputs can contend for a single output, and one input can win two or three outputs at once, so credit ties, the all-zero fallback and a grant that is won but not kept can all be driven directly. Because the arbiters are short, the rotation of a pointer after an accepted grant can be followed through repeated contention for the same output.

// File: rtl/vca_pkg.sv
package vca_pkg;
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/vca_rr_arb.sv
module vca_rr_arb
  import vca_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [IW-1:0] win,
  output logic          win_valid
);
  logic [IW-1:0] ptr;

  always_comb begin
    win       = '0;
    win_valid = 1'b0;
    for (int k = 0; k < N; k++) begin
      int unsigned idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!win_valid && req[idx]) begin
        win       = IW'(idx);
        win_valid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (advance && win_valid) ptr <= IW'(wrap_inc(int'(win), N));
  end

  // R7: the winner is always a live requester
  p_win_requested_r7: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> req[win]);
  // R7: pointer stays put unless the grant is kept
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(ptr));
endmodule

// File: rtl/vca_pick.sv
module vca_pick #(
  parameter int N  = 4,
  parameter int CW = 3,
  parameter int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    won,
  input  logic [N*CW-1:0] credit,
  output logic [IW-1:0]   choice,
  output logic            valid
);
  logic [CW-1:0] best;

  always_comb begin
    best   = '0;
    choice = '0;
    valid  = 1'b0;
    for (int o = 0; o < N; o++) begin
      if (won[o] && (!valid || credit[o*CW +: CW] > best)) begin
        best   = credit[o*CW +: CW];
        choice = IW'(o);
        valid  = 1'b1;
      end
    end
  end

  logic          pick_ok;
  logic [CW-1:0] kept_cr;
  always_comb begin
    kept_cr = credit[int'(choice)*CW +: CW];
    pick_ok = won[choice];
    for (int o = 0; o < N; o++) begin
      if (won[o] && credit[o*CW +: CW] > kept_cr) pick_ok = 1'b0;
      if (won[o] && o < int'(choice) && credit[o*CW +: CW] >= kept_cr) pick_ok = 1'b0;
    end
  end

  // R3 / R4: kept channel has the most credits, lowest index on a tie
  p_pick_max_r3: assert property (@(posedge clk) disable iff (rst)
    valid |-> pick_ok);
endmodule

// File: rtl/vca_alloc.sv
module vca_alloc
  import vca_pkg::*;
#(
  parameter int PORTS  = 5,
  parameter int VCS    = 2,
  parameter int CRED_W = 3
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic [PORTS*VCS*PORTS*VCS-1:0]                  req_i,
  input  logic [PORTS*VCS-1:0]                            full_i,
  input  logic [PORTS*VCS*CRED_W-1:0]                     credit_i,
  input  logic [PORTS*VCS-1:0]                            release_i,
  output logic [PORTS*VCS-1:0]                            grant_valid_o,
  output logic [PORTS*VCS*$clog2(PORTS*VCS)-1:0]          grant_ovc_o
);
  localparam int N  = PORTS * VCS;
  localparam int OW = $clog2(N);

  logic [N-1:0]  pend     [N];
  logic [N-1:0]  col      [N];
  logic [N-1:0]  won      [N];
  logic [OW-1:0] arb_win  [N];
  logic [OW-1:0] pick_idx [N];
  logic [OW-1:0] ovc_q    [N];
  logic [N-1:0]  arb_val, pick_val, accept, freed, busy, gv_q;

  // column view: requesters of each free output channel
  always_comb begin
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++)
        col[o][i] = pend[i][o] & ~busy[o];
  end

  for (genvar o = 0; o < N; o++) begin : g_arb
    vca_rr_arb #(.N(N), .IW(OW)) u_arb (
      .clk(clk), .rst(rst), .req(col[o]), .advance(accept[o]),
      .win(arb_win[o]), .win_valid(arb_val[o])
    );
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      for (int o = 0; o < N; o++)
        won[i][o] = arb_val[o] && (arb_win[o] == OW'(i));
  end

  for (genvar i = 0; i < N; i++) begin : g_pick
    vca_pick #(.N(N), .CW(CRED_W), .IW(OW)) u_pick (
      .clk(clk), .rst(rst), .won(won[i]), .credit(credit_i),
      .choice(pick_idx[i]), .valid(pick_val[i])
    );
  end

  always_comb begin
    for (int o = 0; o < N; o++) begin
      accept[o] = 1'b0;
      freed[o]  = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (won[i][o] && pick_val[i] && pick_idx[i] == OW'(o)) accept[o] = 1'b1;
        if (gv_q[i] && release_i[i] && ovc_q[i] == OW'(o)) freed[o] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
      gv_q <= '0;
      for (int i = 0; i < N; i++) begin
        pend[i]  <= '0;
        ovc_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (pick_val[i]) begin
          gv_q[i]  <= 1'b1;
          ovc_q[i] <= pick_idx[i];
          pend[i]  <= '0;
        end else begin
          if (release_i[i] && gv_q[i]) gv_q[i] <= 1'b0;
          pend[i] <= (pend[i] & req_i[i*N +: N])
                   | (req_i[i*N +: N] & full_i & ~busy & {N{~gv_q[i]}});
        end
      end
      for (int o = 0; o < N; o++) begin
        if (accept[o]) busy[o] <= 1'b1;
        else if (freed[o]) busy[o] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) grant_ovc_o[i*OW +: OW] = ovc_q[i];
  end
  assign grant_valid_o = gv_q;

  logic [N-1:0] owners [N];
  always_comb begin
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++)
        owners[o][i] = gv_q[i] && (ovc_q[i] == OW'(o));
  end

  for (genvar o = 0; o < N; o++) begin : g_chk_o
    // R2: a single holder per output channel
    p_one_owner_r2: assert property (@(posedge clk) disable iff (rst)
      $countones(owners[o]) <= 1);
  end

  for (genvar i = 0; i < N; i++) begin : g_chk_i
    // R6: release drops the allocation on the next edge
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
      gv_q[i] && release_i[i] |=> !gv_q[i]);
    // R10: allocation is held until release
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      gv_q[i] && !release_i[i] |=> gv_q[i] && $stable(ovc_q[i]));
    for (genvar o = 0; o < N; o++) begin : g_chk_io
      // R1: a request is only taken while credits are full
      p_pend_full_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[i][o]) |-> $past(full_i[o]));
    end
  end
endmodule

// File: tb/test_vca_alloc.sv
module test_vca_alloc;
  localparam int PORTS = 3, VCS = 2, CW = 3;
  localparam int N = PORTS * VCS, OW = $clog2(N);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst = 1;
  logic [N*N-1:0]  req = '0;
  logic [N-1:0]    full = '1, rel = '0;
  logic [N*CW-1:0] cred;
  logic [N-1:0]    gv;
  logic [N*OW-1:0] ovc;

  int total = 0, bad = 0;
  int exp_q[$];
  string tag_q[$];
  logic [N-1:0] gv_prev = '0;

  vca_alloc #(.PORTS(PORTS), .VCS(VCS), .CRED_W(CW)) i_vca_alloc (
    .clk(clk), .rst(rst), .req_i(req), .full_i(full), .credit_i(cred),
    .release_i(rel), .grant_valid_o(gv), .grant_ovc_o(ovc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input int i, input int o, input string tag);
    exp_q.push_back(i * 16 + o);
    tag_q.push_back(tag);
  endtask

  // monitor: every new grant must match the next scoreboard item
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        if (gv[i] && !gv_prev[i]) begin
          if (exp_q.size() == 0) chk(0, "R2 unexpected grant", i * 16 + int'(ovc[i*OW +: OW]), -1);
          else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(e == i * 16 + int'(ovc[i*OW +: OW]), t, i * 16 + int'(ovc[i*OW +: OW]), e);
          end
        end
      end
      gv_prev = gv;
    end
  end

  task automatic set_cred(input int o, input int v);
    cred[o*CW +: CW] = CW'(v);
  endtask

  task automatic wait_grant(input int i);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!gv[i] && n < 20);
    chk(gv[i], "R8 grant arrives", int'(gv[i]), 1);
    req[i*N +: N] = '0;
  endtask

  task automatic release_in(input int i);
    rel[i] = 1'b1;
    @(negedge clk);
    rel[i] = 1'b0;
    chk(!gv[i], "R6 release clears grant", int'(gv[i]), 0);
  endtask

  initial begin
    for (int o = 0; o < N; o++) set_cred(o, 4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(gv == '0, "R9 reset state", int'(gv), 0);

    // R8: latency and index encoding (port 1, vc 1 -> 3)
    push(0, 3, "R8 encoding");
    req[0*N + 3] = 1'b1;
    @(negedge clk);
    chk(!gv[0], "R8 not after one edge", int'(gv[0]), 0);
    @(negedge clk);
    chk(gv[0] && ovc[0*OW +: OW] == 3, "R8 after two edges", int'(ovc[0*OW +: OW]), 3);
    req[0*N +: N] = '0;
    release_in(0);

    // R1: no request while credits are not full
    full[5] = 1'b0;
    req[1*N + 5] = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!gv[1], "R1 blocked while not full", int'(gv[1]), 0);
    end
    req[1*N +: N] = '0;
    full[5] = 1'b1;
    @(negedge clk);
    push(1, 5, "R1 granted once full");
    req[1*N + 5] = 1'b1;
    wait_grant(1);
    release_in(1);

    // R3: most credits kept, tie to lowest index
    set_cred(0, 1); set_cred(2, 3); set_cred(4, 3);
    push(2, 2, "R3 max credits tie");
    req[2*N + 0] = 1'b1; req[2*N + 2] = 1'b1; req[2*N + 4] = 1'b1;
    wait_grant(2);
    release_in(2);

    // R4: all won channels at zero credits
    set_cred(1, 0); set_cred(3, 0);
    push(3, 1, "R4 zero credits lowest");
    req[3*N + 1] = 1'b1; req[3*N + 3] = 1'b1;
    wait_grant(3);
    release_in(3);
    for (int o = 0; o < N; o++) set_cred(o, 4);

    // R2/R7/R10: contention on output 2, pointer sits after input 2
    for (int r = 0; r < 2; r++) begin
      push(4, 2, "R7 round robin first");
      push(0, 2, "R7 round robin second");
      req[4*N + 2] = 1'b1; req[0*N + 2] = 1'b1;
      wait_grant(4);
      repeat (3) begin
        @(negedge clk);
        chk(!gv[0], "R2 waiter blocked", int'(gv[0]), 0);
        chk(gv[4] && ovc[4*OW +: OW] == 2, "R10 grant held", int'(ovc[4*OW +: OW]), 2);
      end
      release_in(4);
      wait_grant(0);
      release_in(0);
    end

    // R5: input 0 wins 0 and 1, keeps 1, output 0 goes to input 3
    set_cred(0, 2); set_cred(1, 4);
    push(0, 1, "R5 keep richer channel");
    push(3, 0, "R5 dropped channel regranted");
    req[0*N + 0] = 1'b1; req[0*N + 1] = 1'b1; req[3*N + 0] = 1'b1;
    wait_grant(0);
    chk(!gv[3], "R5 regrant not same cycle", int'(gv[3]), 0);
    @(negedge clk);
    chk(gv[3] && ovc[3*OW +: OW] == 0, "R5 regrant next cycle", int'(ovc[3*OW +: OW]), 0);
    req[3*N +: N] = '0;
    release_in(0);
    release_in(3);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected grants seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule